// File: doc/BRIEF.md
# Retire and Redirect Controller

This block sits at the head of a reorder buffer in an out-of-order core. Every cycle it looks at a window of the oldest buffer entries. It emits pop strobes for the leading run of completed entries, and it never skips an entry that is still in flight. An entry flagged as non-speculative cannot execute until it becomes the oldest entry. At that point the block sends its sequence number back to the issue logic, once, so the entry can be started. A saturating counter records every cycle in which such an entry holds up the head.

The block also acts as the age filter for back-end redirects. It keeps a register holding the sequence number of the youngest valid instruction. Each allocation into the buffer overwrites that register. Several redirect sources may request at once, and the oldest request among them is chosen. That request is accepted only if it is strictly older than the register. An accepted request is broadcast in the same cycle with its squash-until sequence number, its target and its mispredict flag. It then becomes the new youngest value, and it blocks retirement for that cycle.

Top module: `commit_redirect_ctrl`

## Requirements
- R1: `retire[i]` is 1 in the same cycle exactly when entries 0..i are all valid and completed and no squash is broadcast; up to `CW` entries retire per cycle.
- R2: Retirement stops at the first head entry that is invalid or not completed, so entries after it stay unretired even when they are completed (strictly in order).
- R3: When entry 0 is valid, non-speculative and not completed, `rel_vld` pulses for one cycle in the next cycle with `rel_seq` equal to that entry's sequence number, and only once for that sequence number.
- R4: At most one release is issued per cycle, and no release is issued for a cycle in which a squash is broadcast; the release then follows in the next cycle that has no squash.
- R5: The youngest-valid register is 0 after reset, and it takes `alloc_seq` at each clock edge where `alloc_vld` is 1 and no squash is accepted.
- R6: A redirect is accepted only when its sequence number is strictly less (unsigned) than the youngest-valid register. Acceptance drives `sq_vld`, `sq_seq`, `sq_tgt` and `sq_mispred` in that same cycle. An equal or younger redirect is dropped.
- R7: Among redirect sources valid in the same cycle, the smallest sequence number wins; on a tie the lowest source index wins.
- R8: An accepted squash overwrites the youngest-valid register with the winning sequence number, with priority over an allocation in the same cycle.
- R9: No entry is retired in a cycle in which `sq_vld` is 1.
- R10: `stall_cnt` increments by one at each edge after a cycle in which entry 0 is valid, non-speculative and not completed, and holds at its all-ones maximum.
- R11: While reset is asserted, `retire`, `sq_vld`, `rel_vld` and `stall_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| head_vld | input | CW | Head window entry valid; bit 0 is the oldest entry |
| head_done | input | CW | Head window entry has completed execution |
| head_nonspec | input | CW | Head window entry must not execute speculatively |
| head_seq | input | CW*SEQ_W | Sequence numbers of the head window, entry i in bits [i*SEQ_W +: SEQ_W] |
| alloc_vld | input | 1 | An instruction is being allocated into the buffer |
| alloc_seq | input | SEQ_W | Sequence number of the allocated instruction |
| red_vld | input | NR | Redirect request valid per source |
| red_seq | input | NR*SEQ_W | Redirect squash-until sequence number per source |
| red_tgt | input | NR*TGT_W | Redirect target per source |
| red_mispred | input | NR | Redirect is a branch mispredict, per source |
| retire | output | CW | Pop strobes for the head window entries |
| sq_vld | output | 1 | Squash broadcast valid |
| sq_seq | output | SEQ_W | Squash-until sequence number |
| sq_tgt | output | TGT_W | Redirect target of the squash |
| sq_mispred | output | 1 | Squash is caused by a mispredict |
| rel_vld | output | 1 | Non-speculative release pulse |
| rel_seq | output | SEQ_W | Sequence number of the released instruction |
| stall_cnt | output | CNT_W | Saturating count of head stalls caused by non-speculative entries |

## Verification
An accepted redirect can arrive in the same cycle as a fully completed head window, and in the same cycle as a non-speculative entry waiting at the head. The bench builds both cases. It applies a redirect older than the youngest-valid value while every head entry is done, and expects an all-zero retire vector next to the squash broadcast. It then repeats the redirect against a waiting non-speculative entry and expects no release after the squash cycle, followed by the release in the first quiet cycle. A companion case sends an allocation in the same cycle as an accepted redirect. The later acceptance decisions then show that the squash value, not the allocation, became the youngest-valid value.

// File: rtl/commit_pkg.sv
package commit_pkg;
  parameter int unsigned SEQ_W = 32;
  parameter int unsigned TGT_W = 32;
  typedef logic [SEQ_W-1:0] seq_t;
  typedef logic [TGT_W-1:0] tgt_t;
endpackage

// File: rtl/commit_retire_sel.sv
module commit_retire_sel #(
  parameter int unsigned CW = 4
) (
  input  logic [CW-1:0] head_vld,
  input  logic [CW-1:0] head_done,
  input  logic          block,
  output logic [CW-1:0] retire
);
  // run[i] is high while entries 0..i-1 are all retirable
  logic [CW:0] run;
  assign run[0] = 1'b1;

  for (genvar g = 0; g < CW; g++) begin : g_chain
    assign run[g+1]  = run[g] & head_vld[g] & head_done[g];
    assign retire[g] = run[g+1] & ~block;
  end
endmodule

// File: rtl/commit_redirect_arb.sv
module commit_redirect_arb
  import commit_pkg::*;
#(
  parameter int unsigned NR = 3
) (
  input  logic [NR-1:0]       red_vld,
  input  logic [NR*SEQ_W-1:0] red_seq,
  input  logic [NR*TGT_W-1:0] red_tgt,
  input  logic [NR-1:0]       red_mispred,
  output logic                win_vld,
  output seq_t                win_seq,
  output tgt_t                win_tgt,
  output logic                win_mispred
);
  logic [NR:0] c_vld;
  logic [NR:0] c_mis;
  seq_t        c_seq [NR+1];
  tgt_t        c_tgt [NR+1];

  assign c_vld[0] = 1'b0;
  assign c_mis[0] = 1'b0;
  assign c_seq[0] = '0;
  assign c_tgt[0] = '0;

  for (genvar g = 0; g < NR; g++) begin : g_stage
    seq_t s_in;
    logic take;
    assign s_in = red_seq[g*SEQ_W +: SEQ_W];
    // strict compare keeps the lower index on a tie
    assign take       = red_vld[g] & (~c_vld[g] | (s_in < c_seq[g]));
    assign c_vld[g+1] = c_vld[g] | red_vld[g];
    assign c_seq[g+1] = take ? s_in : c_seq[g];
    assign c_tgt[g+1] = take ? red_tgt[g*TGT_W +: TGT_W] : c_tgt[g];
    assign c_mis[g+1] = take ? red_mispred[g] : c_mis[g];
  end

  assign win_vld     = c_vld[NR];
  assign win_seq     = c_seq[NR];
  assign win_tgt     = c_tgt[NR];
  assign win_mispred = c_mis[NR];
endmodule

// File: rtl/commit_nonspec_ctl.sv
module commit_nonspec_ctl
  import commit_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_vld,
  input  logic             h_done,
  input  logic             h_nonspec,
  input  seq_t             h_seq,
  input  logic             squash,
  output logic             rel_vld,
  output seq_t             rel_seq,
  output logic [CNT_W-1:0] stall_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             rel_vld_q, rel_vld_d;
  seq_t             rel_seq_q;
  logic             mark_vld_q;
  seq_t             mark_seq_q;
  logic [CNT_W-1:0] stall_q, stall_d;
  logic             blocked, fire, stall_en;

  always_comb begin
    blocked   = h_vld & h_nonspec & ~h_done;
    fire      = blocked & ~squash & ~(mark_vld_q & (mark_seq_q == h_seq));
    rel_vld_d = fire;
    stall_en  = blocked & (stall_q != CNT_MAX);
    stall_d   = stall_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_vld_q  <= 1'b0;
      rel_seq_q  <= '0;
      mark_vld_q <= 1'b0;
      mark_seq_q <= '0;
      stall_q    <= '0;
    end else begin
      rel_vld_q <= rel_vld_d;
      if (fire) begin
        rel_seq_q  <= h_seq;
        mark_vld_q <= 1'b1;
        mark_seq_q <= h_seq;
      end
      if (stall_en) begin
        stall_q <= stall_d;
      end
    end
  end

  assign rel_vld   = rel_vld_q;
  assign rel_seq   = rel_seq_q;
  assign stall_cnt = stall_q;
endmodule

// File: rtl/commit_redirect_ctrl.sv
module commit_redirect_ctrl
  import commit_pkg::*;
#(
  parameter int unsigned CW    = 4,
  parameter int unsigned NR    = 3,
  parameter int unsigned CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         head_vld,
  input  logic [CW-1:0]         head_done,
  input  logic [CW-1:0]         head_nonspec,
  input  logic [CW*SEQ_W-1:0]   head_seq,
  input  logic                  alloc_vld,
  input  logic [SEQ_W-1:0]      alloc_seq,
  input  logic [NR-1:0]         red_vld,
  input  logic [NR*SEQ_W-1:0]   red_seq,
  input  logic [NR*TGT_W-1:0]   red_tgt,
  input  logic [NR-1:0]         red_mispred,
  output logic [CW-1:0]         retire,
  output logic                  sq_vld,
  output logic [SEQ_W-1:0]      sq_seq,
  output logic [TGT_W-1:0]      sq_tgt,
  output logic                  sq_mispred,
  output logic                  rel_vld,
  output logic [SEQ_W-1:0]      rel_seq,
  output logic [CNT_W-1:0]      stall_cnt
);
  logic win_vld, win_mispred, accept, yng_en;
  seq_t win_seq, yng_q, yng_d;
  tgt_t win_tgt;

  commit_redirect_arb #(.NR(NR)) u_arb (
    .red_vld     (red_vld),
    .red_seq     (red_seq),
    .red_tgt     (red_tgt),
    .red_mispred (red_mispred),
    .win_vld     (win_vld),
    .win_seq     (win_seq),
    .win_tgt     (win_tgt),
    .win_mispred (win_mispred)
  );

  // age filter against the youngest valid instruction
  always_comb begin
    accept = win_vld & (win_seq < yng_q);
    yng_en = accept | alloc_vld;
    yng_d  = accept ? win_seq : alloc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      yng_q <= '0;
    end else if (yng_en) begin
      yng_q <= yng_d;
    end
  end

  assign sq_vld     = accept;
  assign sq_seq     = win_seq;
  assign sq_tgt     = win_tgt;
  assign sq_mispred = win_mispred;

  commit_retire_sel #(.CW(CW)) u_ret (
    .head_vld  (head_vld),
    .head_done (head_done),
    .block     (accept),
    .retire    (retire)
  );

  commit_nonspec_ctl #(.CNT_W(CNT_W)) u_ns (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_vld     (head_vld[0]),
    .h_done    (head_done[0]),
    .h_nonspec (head_nonspec[0]),
    .h_seq     (head_seq[SEQ_W-1:0]),
    .squash    (accept),
    .rel_vld   (rel_vld),
    .rel_seq   (rel_seq),
    .stall_cnt (stall_cnt)
  );
endmodule

// File: rtl/commit_redirect_ctrl_chk.sv
module commit_redirect_ctrl_chk
  import commit_pkg::*;
#(
  parameter int unsigned CW    = 4,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    head_vld,
  input logic [CW-1:0]    head_done,
  input logic [CW-1:0]    head_nonspec,
  input logic [CW-1:0]    retire,
  input logic             sq_vld,
  input seq_t             sq_seq,
  input seq_t             yng_q,
  input logic             rel_vld,
  input logic [CNT_W-1:0] stall_cnt
);
  for (genvar g = 0; g < CW; g++) begin : g_ret
    p_retire_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      retire[g] |-> (head_vld[g] && head_done[g]));
    if (g > 0) begin : g_ord
      p_retire_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        retire[g] |-> retire[g-1]);
    end
  end

  p_quiet_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld |-> (retire == '0));

  p_older_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld |-> (sq_seq < yng_q));

  p_yng_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sq_vld |=> (yng_q == $past(sq_seq)));

  p_rel_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld |-> $past(head_vld[0] && head_nonspec[0] && !head_done[0] && !sq_vld));

  p_stall_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld[0] && head_nonspec[0] && !head_done[0] && (stall_cnt != {CNT_W{1'b1}}))
      |=> (stall_cnt == CNT_W'($past(stall_cnt) + 1'b1)));
endmodule

bind commit_redirect_ctrl commit_redirect_ctrl_chk #(.CW(CW), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .head_vld     (head_vld),
  .head_done    (head_done),
  .head_nonspec (head_nonspec),
  .retire       (retire),
  .sq_vld       (sq_vld),
  .sq_seq       (sq_seq),
  .yng_q        (yng_q),
  .rel_vld      (rel_vld),
  .stall_cnt    (stall_cnt)
);

// File: tb/commit_redirect_ctrl_tb.sv
module commit_redirect_ctrl_tb;
  localparam int CW = 4;
  localparam int NR = 3;
  localparam int CNT_W = 8;

  logic clk, rst_n;
  logic [CW-1:0] head_vld, head_done, head_nonspec;
  logic [31:0] hs [CW];
  logic [CW*32-1:0] head_seq;
  logic alloc_vld;
  logic [31:0] alloc_seq;
  logic [NR-1:0] red_vld, red_mispred;
  logic [31:0] rs [NR];
  logic [31:0] rt [NR];
  logic [NR*32-1:0] red_seq, red_tgt;
  logic [CW-1:0] retire;
  logic sq_vld, sq_mispred, rel_vld;
  logic [31:0] sq_seq, sq_tgt, rel_seq;
  logic [CNT_W-1:0] stall_cnt;

  assign head_seq = {hs[3], hs[2], hs[1], hs[0]};
  assign red_seq  = {rs[2], rs[1], rs[0]};
  assign red_tgt  = {rt[2], rt[1], rt[0]};

  commit_redirect_ctrl #(.CW(CW), .NR(NR), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .head_vld(head_vld), .head_done(head_done), .head_nonspec(head_nonspec),
    .head_seq(head_seq), .alloc_vld(alloc_vld), .alloc_seq(alloc_seq),
    .red_vld(red_vld), .red_seq(red_seq), .red_tgt(red_tgt), .red_mispred(red_mispred),
    .retire(retire), .sq_vld(sq_vld), .sq_seq(sq_seq), .sq_tgt(sq_tgt),
    .sq_mispred(sq_mispred), .rel_vld(rel_vld), .rel_seq(rel_seq), .stall_cnt(stall_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tot = 0, n_bad = 0;
  bit finished = 0;

  typedef struct {
    int          due;
    int          kind;
    logic [63:0] val;
    string       req;
  } exp_t;
  exp_t sb [$];

  // staged stimulus, applied by step()
  logic [CW-1:0] s_hv, s_hd, s_hn;
  logic [31:0] s_hs [CW];
  logic s_av;
  logic [31:0] s_as;
  logic [NR-1:0] s_rv, s_rm;
  logic [31:0] s_rs [NR];
  logic [31:0] s_rt [NR];

  // reference state built from the requirements
  logic [31:0] m_yng;
  logic m_mk;
  logic [31:0] m_mks;
  int m_stall;

  function automatic logic [63:0] observe(int kind);
    case (kind)
      0: return 64'(retire);
      1: return 64'(sq_vld);
      2: return 64'(sq_seq);
      3: return 64'(sq_tgt);
      4: return 64'(sq_mispred);
      5: return 64'(rel_vld);
      6: return 64'(rel_seq);
      default: return 64'(stall_cnt);
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    n_tot++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops due expectations and compares
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, observe(e.kind), e.val);
    end
  end

  task automatic push(int due, int kind, logic [63:0] v, string req);
    sb.push_back('{due, kind, v, req});
  endtask

  task automatic idle();
    s_hv = '0; s_hd = '0; s_hn = '0; s_av = 1'b0; s_as = '0;
    s_rv = '0; s_rm = '0;
    for (int i = 0; i < CW; i++) s_hs[i] = '0;
    for (int k = 0; k < NR; k++) begin s_rs[k] = '0; s_rt[k] = '0; end
  endtask

  // driver: applies staged inputs and queues expected results
  task automatic step();
    logic ok, found, bm, acc, blk, fire;
    logic [31:0] best, bt;
    logic [CW-1:0] er;
    @(posedge clk);
    #1;
    head_vld = s_hv; head_done = s_hd; head_nonspec = s_hn;
    for (int i = 0; i < CW; i++) hs[i] = s_hs[i];
    alloc_vld = s_av; alloc_seq = s_as;
    red_vld = s_rv; red_mispred = s_rm;
    for (int k = 0; k < NR; k++) begin rs[k] = s_rs[k]; rt[k] = s_rt[k]; end

    ok = 1'b1;
    for (int i = 0; i < CW; i++) begin
      ok = ok & s_hv[i] & s_hd[i];
      er[i] = ok;
    end
    found = 1'b0; best = '0; bt = '0; bm = 1'b0;
    for (int k = 0; k < NR; k++) begin
      if (s_rv[k] && (!found || s_rs[k] < best)) begin
        found = 1'b1; best = s_rs[k]; bt = s_rt[k]; bm = s_rm[k];
      end
    end
    acc = found && (best < m_yng);
    if (acc) er = '0;
    push(cyc, 0, 64'(er), "R1 R2 R9 retire");
    push(cyc, 1, 64'(acc), "R5 R6 sq_vld");
    if (acc) begin
      push(cyc, 2, 64'(best), "R7 R8 sq_seq");
      push(cyc, 3, 64'(bt), "R6 R7 sq_tgt");
      push(cyc, 4, 64'(bm), "R6 sq_mispred");
    end
    if (acc) m_yng = best;
    else if (s_av) m_yng = s_as;

    blk  = s_hv[0] & s_hn[0] & ~s_hd[0];
    fire = blk && !(m_mk && m_mks == s_hs[0]) && !acc;
    push(cyc + 1, 5, 64'(fire), "R3 R4 rel_vld");
    if (fire) begin
      push(cyc + 1, 6, 64'(s_hs[0]), "R3 rel_seq");
      m_mk = 1'b1; m_mks = s_hs[0];
    end
    if (blk && m_stall != 255) m_stall++;
    push(cyc + 1, 7, 64'(m_stall), "R10 stall_cnt");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog req=all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    m_yng = '0; m_mk = 1'b0; m_mks = '0; m_stall = 0;
    idle();
    rst_n = 1'b0;
    head_vld = '0; head_done = '0; head_nonspec = '0;
    alloc_vld = 1'b0; alloc_seq = '0; red_vld = '0; red_mispred = '0;
    for (int i = 0; i < CW; i++) hs[i] = '0;
    for (int k = 0; k < NR; k++) begin rs[k] = '0; rt[k] = '0; end
    repeat (3) @(negedge clk);
    check("R11 retire", 64'(retire), 64'(0));
    check("R11 sq_vld", 64'(sq_vld), 64'(0));
    check("R11 rel_vld", 64'(rel_vld), 64'(0));
    check("R11 stall_cnt", 64'(stall_cnt), 64'(0));
    rst_n = 1'b1;

    idle(); step();
    // R1: full window retires
    idle(); s_hv = 4'hF; s_hd = 4'hF; step();
    // R2: gaps stop retirement
    idle(); s_hv = 4'hF; s_hd = 4'b1011; step();
    idle(); s_hv = 4'hF; s_hd = 4'b1101; step();
    idle(); s_hv = 4'hF; s_hd = 4'b1110; step();
    idle(); s_hv = 4'b0011; s_hd = 4'hF; step();
    idle(); s_hv = 4'b1011; s_hd = 4'hF; step();
    // R5: youngest is 0 after reset, so this is dropped; allocation lands
    idle(); s_av = 1'b1; s_as = 32'd100; s_rv = 3'b001; s_rs[0] = 32'd50; step();
    // R5 R6 R9: older redirect accepted over a completed window
    idle(); s_hv = 4'hF; s_hd = 4'hF;
    s_rv = 3'b010; s_rs[1] = 32'd99; s_rt[1] = 32'h0ABC; s_rm = 3'b010; step();
    // R8: youngest now 99; equal and younger are dropped
    idle(); s_rv = 3'b001; s_rs[0] = 32'd99; step();
    idle(); s_rv = 3'b100; s_rs[2] = 32'd120; step();
    idle(); s_av = 1'b1; s_as = 32'd200; step();
    // R7 R8: smallest wins, allocation in same cycle loses
    idle(); s_hv = 4'h3; s_hd = 4'h3; s_av = 1'b1; s_as = 32'd300;
    s_rv = 3'b111; s_rs[0] = 32'd150; s_rs[1] = 32'd120; s_rs[2] = 32'd130;
    s_rt[0] = 32'h11; s_rt[1] = 32'h22; s_rt[2] = 32'h33; s_rm = 3'b101; step();
    idle(); s_rv = 3'b001; s_rs[0] = 32'd125; step();
    idle(); s_rv = 3'b001; s_rs[0] = 32'd110; s_rm = 3'b001; s_rt[0] = 32'h44; step();
    // R7: tie goes to lowest index
    idle(); s_av = 1'b1; s_as = 32'd500; step();
    idle(); s_rv = 3'b110; s_rs[1] = 32'd400; s_rs[2] = 32'd400;
    s_rt[1] = 32'hAA; s_rt[2] = 32'hBB; step();
    idle(); s_av = 1'b1; s_as = 32'd600; step();
    // R3: release once, stall counted
    idle(); s_hv = 4'h1; s_hn = 4'h1; s_hs[0] = 32'd77; step();
    idle(); s_hv = 4'h1; s_hn = 4'h1; s_hs[0] = 32'd77; step();
    idle(); s_hv = 4'h3; s_hd = 4'h3; s_hn = 4'h1; s_hs[0] = 32'd77; step();
    // R4: release held off by a squash, then issued
    idle(); s_hv = 4'h1; s_hn = 4'h1; s_hs[0] = 32'd78;
    s_rv = 3'b001; s_rs[0] = 32'd590; step();
    idle(); s_hv = 4'h1; s_hn = 4'h1; s_hs[0] = 32'd78; step();
    // R10: saturation
    for (int n = 0; n < 260; n++) begin
      idle(); s_hv = 4'h1; s_hn = 4'h1; s_hs[0] = 32'd79; step();
    end
    idle(); step();
    idle(); step();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule